// File: doc/BRIEF.md
# SPI Status Flag Logic

This block holds the status flags of an SPI peripheral that has optional transmit and receive FIFOs. The shift engine sends it single-cycle event pulses, and the two FIFOs report their fill levels. It also receives the SPI enable, the FIFO enable and two programmable thresholds. From these inputs it keeps a 32-bit read-only status word.

The bus side gives the block three strobes: a status-word read, a transmit-data write and a receive-data read. Different flags clear on different strobes. Most error and event flags are sticky and clear when the status word is read. The transmit-ready flag clears on a data write, and the receive-full flag clears on a data read. The FIFO flags fire only when a level crosses a boundary, and they are held at zero while the FIFOs are switched off. The transmit-ready and receive-full bits mean different things depending on whether the FIFOs are on.

Every status bit comes from a flop. Each bit therefore shows the inputs sampled at the most recent rising clock edge.

Top module: `spi_status_flags`

## Requirements
- R1: While reset is asserted, and at the first edge after it, the status word is all zeros. Bits 23:17, 15:13 and 7:4 always read 0.
- R2: Bit 16 equals the `spi_en` value sampled at the previous edge.
- R3: Bits 12 (frame error), 11 (compare hit), 10 (underrun), 8 (chip-select rise) and 2 (mode fault) each set on their event pulse. Each stays set until a status read. When a pulse and a status read happen in the same cycle, the flag ends up set.
- R4: Bit 3 (overrun) sets on a receive load while the previous character is still unread, unless that character is read in the same cycle. With FIFOs off, "unread" means bit 0 is set. With FIFOs on, it means the receive level equals FIFO_DEPTH. Bit 3 clears on a status read.
- R5: When `fifo_en` is low, bits 31:24 read 0. Level changes seen while the FIFOs are off leave no flag behind when they are switched back on.
- R6: Bit 29 sets when the receive level goes from below `rx_thresh` to at or above it. It does not set while the level stays at or above the threshold. It clears on a status read.
- R7: Bit 28 sets when the receive level moves to FIFO_DEPTH from any other value. Bit 27 sets when the receive level moves to 0 from any other value. Both clear on a status read.
- R8: Bit 26 sets when the transmit level goes from above `tx_thresh` to at or below it. Bit 25 sets when the transmit level moves to FIFO_DEPTH. Bit 24 sets when the transmit level moves to 0. All three clear on a status read.
- R9: Bits 31 and 30 set on the receive and transmit FIFO pointer-error pulses. Status reads do not clear them. Only reset or a low `fifo_en` clears them.
- R10: Bit 9 (TXEMPTY) is 1 when the transmit holding stage is empty (FIFOs off: bit 1 set; FIFOs on: transmit level 0) and `shifter_idle` is high. A transmit-data write forces it to 0.
- R11: With FIFOs off, bit 1 (TDRE) behaves as follows. It is 0 while `spi_en` is low and becomes 1 when `spi_en` rises. A transmit-data write clears it, and `tx_load` sets it. A write in the same cycle as a load leaves it 0.
- R12: With FIFOs off, bit 0 (RDRF) sets on `rx_load` and clears on `rdr_rd`. If both happen in the same cycle, it stays set.
- R13: With FIFOs on, bit 1 is 1 exactly when the transmit level is below FIFO_DEPTH, and bit 0 is 1 exactly when the receive level is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_en | input | 1 | SPI enabled |
| fifo_en | input | 1 | FIFOs enabled |
| rx_level | input | CNT_W | Unread entries in receive FIFO |
| tx_level | input | CNT_W | Entries in transmit FIFO |
| rx_thresh | input | CNT_W | Receive threshold |
| tx_thresh | input | CNT_W | Transmit threshold |
| ev_frame_err | input | 1 | Client frame error pulse |
| ev_cmp_hit | input | 1 | Received character matched compare pulse |
| ev_underrun | input | 1 | Transfer started with no transmit data pulse |
| ev_cs_rise | input | 1 | Chip-select rising edge pulse |
| ev_mode_fault | input | 1 | Mode fault pulse |
| ev_rx_ptr_err | input | 1 | Receive FIFO pointer error pulse |
| ev_tx_ptr_err | input | 1 | Transmit FIFO pointer error pulse |
| rx_load | input | 1 | Received character moved out of shifter |
| tx_load | input | 1 | Transmit data moved into shifter |
| shifter_idle | input | 1 | Shift register empty and inter-transfer delay expired |
| status_rd | input | 1 | Status word read strobe |
| tdr_wr | input | 1 | Transmit data write strobe |
| rdr_rd | input | 1 | Receive data read strobe |
| status | output | 32 | Status word |

## Verification
Every status bit sits one register stage behind the inputs. A stimulus that is stable at a rising edge therefore shows up on `status` right after that edge and not before. The bench changes inputs 1 ns after an edge and compares `status` 1 ns after the next edge. Each check therefore sees exactly the one edge that sampled the stimulus. The FIFO sweep needs a settled previous level before it can test a transition. It holds each previous level for two edges with a status read active, so that any flag left over from the prior step is cleared. Only then does it apply the new level and compare after the single edge that follows.

// File: rtl/spi_sts_pkg.sv
package spi_sts_pkg;
    localparam int STS_W = 32;

    localparam int B_RX_PTR   = 31;
    localparam int B_TX_PTR   = 30;
    localparam int B_RX_THR   = 29;
    localparam int B_RX_FULL  = 28;
    localparam int B_RX_EMPTY = 27;
    localparam int B_TX_THR   = 26;
    localparam int B_TX_FULL  = 25;
    localparam int B_TX_EMPTY = 24;
    localparam int B_ENABLED  = 16;
    localparam int B_FRAME    = 12;
    localparam int B_CMP      = 11;
    localparam int B_UNDER    = 10;
    localparam int B_TXEMPTY  = 9;
    localparam int B_CSRISE   = 8;
    localparam int B_OVR      = 3;
    localparam int B_MODF     = 2;
    localparam int B_TDRE     = 1;
    localparam int B_RDRF     = 0;

    // sticky bank slot order
    localparam int S_FRAME = 0;
    localparam int S_CMP   = 1;
    localparam int S_UNDER = 2;
    localparam int S_CSR   = 3;
    localparam int S_OVR   = 4;
    localparam int S_MODF  = 5;
    localparam int N_STICKY = 6;

    localparam logic [STS_W-1:0] UNUSED_MASK = 32'h00FE_E0F0;
endpackage

// File: rtl/sts_sticky_bank.sv
module sts_sticky_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        // a set pulse outranks the clearing read
        bank_d.flags = (bank_q.flags & ~{N{clr_i}}) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign flags_o = bank_q.flags;

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]);
        p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i[i]) |=> !flags_o[i]);
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i && flags_o[i]) |=> flags_o[i]);
    end
endmodule

// File: rtl/sts_fifo_edge.sv
module sts_fifo_edge #(
    parameter int DEPTH = 8,
    parameter int CW    = 4,
    parameter bit IS_TX = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en_i,
    input  logic [CW-1:0] level_i,
    input  logic [CW-1:0] thresh_i,
    input  logic          ptr_err_i,
    input  logic          clr_i,
    output logic          ptr_o,
    output logic          thr_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam logic [CW-1:0] FULL_V = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] prev;
        logic          ptr;
        logic          thr;
        logic          full;
        logic          empty;
    } edge_t;

    edge_t st_d, st_q;
    logic  hit_thr, hit_full, hit_empty;

    if (IS_TX) begin : g_tx
        // draining direction: crossing down to the threshold
        assign hit_thr = (st_q.prev > thresh_i) && (level_i <= thresh_i);
    end else begin : g_rx
        // filling direction: crossing up to the threshold
        assign hit_thr = (st_q.prev < thresh_i) && (level_i >= thresh_i);
    end

    assign hit_full  = (st_q.prev != FULL_V) && (level_i == FULL_V);
    assign hit_empty = (st_q.prev != '0)     && (level_i == '0);

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        if (!fifo_en_i) begin
            st_d.ptr   = 1'b0;
            st_d.thr   = 1'b0;
            st_d.full  = 1'b0;
            st_d.empty = 1'b0;
        end else begin
            st_d.ptr   = st_q.ptr | ptr_err_i;
            st_d.thr   = (st_q.thr   & ~clr_i) | hit_thr;
            st_d.full  = (st_q.full  & ~clr_i) | hit_full;
            st_d.empty = (st_q.empty & ~clr_i) | hit_empty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o   = st_q.ptr;
    assign thr_o   = st_q.thr;
    assign full_o  = st_q.full;
    assign empty_o = st_q.empty;

    p_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en_i |=> !(ptr_o || thr_o || full_o || empty_o));
    p_full_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en_i && level_i == FULL_V && st_q.prev != FULL_V) |=> full_o);
    p_thr_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en_i && clr_i && level_i == st_q.prev) |=> !thr_o);
    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en_i && ptr_o) |=> (ptr_o || !fifo_en_i));
endmodule

// File: rtl/sts_xfer_ready.sv
module sts_xfer_ready #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_en_i,
    input  logic          fifo_en_i,
    input  logic [CW-1:0] tx_level_i,
    input  logic [CW-1:0] rx_level_i,
    input  logic          tdr_wr_i,
    input  logic          tx_load_i,
    input  logic          rx_load_i,
    input  logic          rdr_rd_i,
    input  logic          sh_idle_i,
    output logic          tdre_o,
    output logic          rdrf_o,
    output logic          txempty_o,
    output logic          ovr_evt_o
);
    localparam logic [CW-1:0] FULL_V = CW'(DEPTH);

    typedef struct packed {
        logic en_prev;
        logic tdre_nf;
        logic rdrf_nf;
        logic tdre;
        logic rdrf;
        logic txempty;
    } xfer_t;

    xfer_t st_d, st_q;
    logic  en_rise;
    logic  hold_empty;

    assign en_rise = spi_en_i && !st_q.en_prev;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = spi_en_i;

        // single-register mode transmit tracking
        if (!spi_en_i)      st_d.tdre_nf = 1'b0;
        else if (en_rise)   st_d.tdre_nf = 1'b1;
        else if (tdr_wr_i)  st_d.tdre_nf = 1'b0;
        else if (tx_load_i) st_d.tdre_nf = 1'b1;

        // single-register mode receive tracking, arrival wins over read
        if (rx_load_i)     st_d.rdrf_nf = 1'b1;
        else if (rdr_rd_i) st_d.rdrf_nf = 1'b0;

        st_d.tdre = fifo_en_i ? (tx_level_i != FULL_V) : st_d.tdre_nf;
        st_d.rdrf = fifo_en_i ? (rx_level_i != '0)     : st_d.rdrf_nf;

        hold_empty   = fifo_en_i ? (tx_level_i == '0) : st_d.tdre_nf;
        st_d.txempty = hold_empty && sh_idle_i && !tdr_wr_i;
    end

    always_comb begin
        if (fifo_en_i) ovr_evt_o = rx_load_i && (rx_level_i == FULL_V) && !rdr_rd_i;
        else           ovr_evt_o = rx_load_i && st_q.rdrf_nf && !rdr_rd_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tdre_o    = st_q.tdre;
    assign rdrf_o    = st_q.rdrf;
    assign txempty_o = st_q.txempty;

    p_wr_clears_txempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tdr_wr_i |=> !txempty_o);
    p_off_tdre_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_en_i && !fifo_en_i) |=> !tdre_o);
    p_load_sets_rdrf_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load_i && !fifo_en_i) |=> rdrf_o);
    p_fifo_rdrf_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en_i && rx_level_i == '0) |=> !rdrf_o);
endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags
    import spi_sts_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_en,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic [CNT_W-1:0] rx_thresh,
    input  logic [CNT_W-1:0] tx_thresh,
    input  logic             ev_frame_err,
    input  logic             ev_cmp_hit,
    input  logic             ev_underrun,
    input  logic             ev_cs_rise,
    input  logic             ev_mode_fault,
    input  logic             ev_rx_ptr_err,
    input  logic             ev_tx_ptr_err,
    input  logic             rx_load,
    input  logic             tx_load,
    input  logic             shifter_idle,
    input  logic             status_rd,
    input  logic             tdr_wr,
    input  logic             rdr_rd,
    output logic [31:0]      status
);
    typedef struct packed {
        logic enabled;
    } top_t;

    top_t top_d, top_q;

    logic [N_STICKY-1:0] stk_set, stk_q;
    logic rx_ptr, rx_thr, rx_full, rx_empty;
    logic tx_ptr, tx_thr, tx_full, tx_empty;
    logic tdre, rdrf, txempty, ovr_evt;

    always_comb begin
        top_d         = top_q;
        top_d.enabled = spi_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    sts_xfer_ready #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_en_i   (spi_en),
        .fifo_en_i  (fifo_en),
        .tx_level_i (tx_level),
        .rx_level_i (rx_level),
        .tdr_wr_i   (tdr_wr),
        .tx_load_i  (tx_load),
        .rx_load_i  (rx_load),
        .rdr_rd_i   (rdr_rd),
        .sh_idle_i  (shifter_idle),
        .tdre_o     (tdre),
        .rdrf_o     (rdrf),
        .txempty_o  (txempty),
        .ovr_evt_o  (ovr_evt)
    );

    always_comb begin
        stk_set          = '0;
        stk_set[S_FRAME] = ev_frame_err;
        stk_set[S_CMP]   = ev_cmp_hit;
        stk_set[S_UNDER] = ev_underrun;
        stk_set[S_CSR]   = ev_cs_rise;
        stk_set[S_OVR]   = ovr_evt;
        stk_set[S_MODF]  = ev_mode_fault;
    end

    sts_sticky_bank #(.N(N_STICKY)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (stk_set),
        .clr_i   (status_rd),
        .flags_o (stk_q)
    );

    sts_fifo_edge #(.DEPTH(FIFO_DEPTH), .CW(CNT_W), .IS_TX(1'b0)) u_rx_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en_i (fifo_en),
        .level_i   (rx_level),
        .thresh_i  (rx_thresh),
        .ptr_err_i (ev_rx_ptr_err),
        .clr_i     (status_rd),
        .ptr_o     (rx_ptr),
        .thr_o     (rx_thr),
        .full_o    (rx_full),
        .empty_o   (rx_empty)
    );

    sts_fifo_edge #(.DEPTH(FIFO_DEPTH), .CW(CNT_W), .IS_TX(1'b1)) u_tx_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en_i (fifo_en),
        .level_i   (tx_level),
        .thresh_i  (tx_thresh),
        .ptr_err_i (ev_tx_ptr_err),
        .clr_i     (status_rd),
        .ptr_o     (tx_ptr),
        .thr_o     (tx_thr),
        .full_o    (tx_full),
        .empty_o   (tx_empty)
    );

    always_comb begin
        status             = '0;
        status[B_RX_PTR]   = rx_ptr;
        status[B_TX_PTR]   = tx_ptr;
        status[B_RX_THR]   = rx_thr;
        status[B_RX_FULL]  = rx_full;
        status[B_RX_EMPTY] = rx_empty;
        status[B_TX_THR]   = tx_thr;
        status[B_TX_FULL]  = tx_full;
        status[B_TX_EMPTY] = tx_empty;
        status[B_ENABLED]  = top_q.enabled;
        status[B_FRAME]    = stk_q[S_FRAME];
        status[B_CMP]      = stk_q[S_CMP];
        status[B_UNDER]    = stk_q[S_UNDER];
        status[B_TXEMPTY]  = txempty;
        status[B_CSRISE]   = stk_q[S_CSR];
        status[B_OVR]      = stk_q[S_OVR];
        status[B_MODF]     = stk_q[S_MODF];
        status[B_TDRE]     = tdre;
        status[B_RDRF]     = rdrf;
    end

    p_en_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |=> status[B_ENABLED]);
    p_en_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |=> !status[B_ENABLED]);
    p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_load && !fifo_en && rdrf && !rdr_rd) |=> status[B_OVR]);
endmodule

// File: tb/test_spi_status_flags.sv
`timescale 1ns/1ps
module test_spi_status_flags;
    logic clk = 1'b0;
    logic rst_n;
    logic spi_en, fifo_en;
    logic [3:0] rx_level, tx_level, rx_thresh, tx_thresh;
    logic ev_frame_err, ev_cmp_hit, ev_underrun, ev_cs_rise, ev_mode_fault;
    logic ev_rx_ptr_err, ev_tx_ptr_err;
    logic rx_load, tx_load, shifter_idle, status_rd, tdr_wr, rdr_rd;
    logic [31:0] status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    spi_status_flags i_spi_status_flags (
        .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .fifo_en(fifo_en),
        .rx_level(rx_level), .tx_level(tx_level),
        .rx_thresh(rx_thresh), .tx_thresh(tx_thresh),
        .ev_frame_err(ev_frame_err), .ev_cmp_hit(ev_cmp_hit),
        .ev_underrun(ev_underrun), .ev_cs_rise(ev_cs_rise),
        .ev_mode_fault(ev_mode_fault), .ev_rx_ptr_err(ev_rx_ptr_err),
        .ev_tx_ptr_err(ev_tx_ptr_err), .rx_load(rx_load), .tx_load(tx_load),
        .shifter_idle(shifter_idle), .status_rd(status_rd),
        .tdr_wr(tdr_wr), .rdr_rd(rdr_rd), .status(status)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic quiet();
        ev_frame_err = 0; ev_cmp_hit = 0; ev_underrun = 0; ev_cs_rise = 0;
        ev_mode_fault = 0; ev_rx_ptr_err = 0; ev_tx_ptr_err = 0;
        rx_load = 0; tx_load = 0; status_rd = 0; tdr_wr = 0; rdr_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; spi_en = 0; fifo_en = 0; shifter_idle = 0;
        rx_level = 0; tx_level = 0; rx_thresh = 0; tx_thresh = 0;
        quiet();
        repeat (3) tick();
        chk("R1 in reset", status, 32'h0);
        rst_n = 1;
        tick();
        chk("R1 after reset", status, 32'h0);

        // R2 / R11: enabling sets TDRE and mirrors enable
        spi_en = 1;
        tick();
        chk("R2 enable bit", status & 32'h0001_0202, 32'h0001_0002);
        shifter_idle = 1;
        tick();
        chk("R10 txempty set", status & 32'h0000_0202, 32'h0000_0202);

        tdr_wr = 1; tick(); tdr_wr = 0;
        chk("R10 R11 write clears", status & 32'h0000_0202, 32'h0);
        tx_load = 1; shifter_idle = 0; tick(); tx_load = 0;
        chk("R11 load sets tdre", status & 32'h0000_0202, 32'h0000_0002);
        shifter_idle = 1; tick();
        chk("R10 idle after load", status & 32'h0000_0202, 32'h0000_0202);
        tdr_wr = 1; tx_load = 1; tick(); quiet();
        chk("R11 write with load", status & 32'h0000_0002, 32'h0);
        tx_load = 1; tick(); quiet();
        chk("R11 reload", status & 32'h0000_0002, 32'h2);
        spi_en = 0; tick();
        chk("R11 R2 disable", status & 32'h0001_0202, 32'h0);
        spi_en = 1; tick();
        chk("R11 re-enable", status & 32'h0001_0002, 32'h0001_0002);

        // R12 / R4 single-register receive
        rx_load = 1; tick(); quiet();
        chk("R12 load", status & 32'h9, 32'h1);
        rx_load = 1; tick(); quiet();
        chk("R4 overrun", status & 32'h9, 32'h9);
        rdr_rd = 1; tick(); quiet();
        chk("R12 read clears", status & 32'h9, 32'h8);
        status_rd = 1; tick(); quiet();
        chk("R4 status read clears", status & 32'h9, 32'h0);
        rx_load = 1; tick(); quiet();
        rx_load = 1; rdr_rd = 1; tick(); quiet();
        chk("R12 R4 load with read", status & 32'h9, 32'h1);
        rdr_rd = 1; tick(); quiet();
        chk("R12 cleared", status & 32'h1, 32'h0);

        // R3 sweep: every event combination together with a clearing read
        for (int m = 0; m < 32; m++) begin
            logic [31:0] e;
            ev_frame_err = m[0]; ev_cmp_hit = m[1]; ev_underrun = m[2];
            ev_cs_rise = m[3]; ev_mode_fault = m[4]; status_rd = 1;
            tick(); quiet();
            e = 0;
            e[12] = m[0]; e[11] = m[1]; e[10] = m[2]; e[8] = m[3]; e[2] = m[4];
            chk("R3 sticky set-wins", status & 32'h0000_1D0C, e);
        end
        tick();
        chk("R3 hold", status & 32'h0000_1D0C, 32'h0000_1D04);
        status_rd = 1; tick(); quiet();
        chk("R3 read clears", status & 32'h0000_1D0C, 32'h0);

        // R4 with FIFOs on
        fifo_en = 1; rx_level = 8; tx_level = 0; rx_thresh = 8; tx_thresh = 0;
        status_rd = 1; tick(); tick(); quiet();
        rx_load = 1; tick(); quiet();
        chk("R4 fifo full overrun", status & 32'h8, 32'h8);
        status_rd = 1; tick(); quiet();

        // R6 R7 R8 R13 sweep
        shifter_idle = 0;
        for (int th = 0; th <= 8; th++) begin
            for (int p = 0; p <= 8; p++) begin
                for (int c = 0; c <= 8; c++) begin
                    logic [31:0] e;
                    rx_thresh = 4'(th); tx_thresh = 4'(th);
                    rx_level = 4'(p); tx_level = 4'(p);
                    status_rd = 1; tick(); tick(); status_rd = 0;
                    rx_level = 4'(c); tx_level = 4'(c);
                    tick();
                    e = 0;
                    e[29] = (p < th) && (c >= th);
                    e[28] = (p != 8) && (c == 8);
                    e[27] = (p != 0) && (c == 0);
                    e[26] = (p > th) && (c <= th);
                    e[25] = (p != 8) && (c == 8);
                    e[24] = (p != 0) && (c == 0);
                    e[1]  = (c != 8);
                    e[0]  = (c != 0);
                    chk("R6 R7 R8 R13 level sweep", status & 32'h3F00_0003, e);
                end
            end
        end

        // R9 pointer errors, R5 disable
        rx_level = 3; tx_level = 3; rx_thresh = 8; tx_thresh = 0;
        status_rd = 1; tick(); tick(); quiet();
        ev_rx_ptr_err = 1; tick(); quiet();
        chk("R9 rx ptr", status & 32'hFF00_0000, 32'h8000_0000);
        ev_tx_ptr_err = 1; tick(); quiet();
        chk("R9 tx ptr", status & 32'hFF00_0000, 32'hC000_0000);
        status_rd = 1; tick(); quiet();
        chk("R9 survives read", status & 32'hFF00_0000, 32'hC000_0000);
        fifo_en = 0; tick();
        chk("R5 disable clears", status & 32'hFF00_0000, 32'h0);
        rx_level = 8; tx_level = 0; tick();
        chk("R5 off no flags", status & 32'hFF00_0000, 32'h0);
        fifo_en = 1; tick();
        chk("R5 re-enable clean", status & 32'hFF00_0000, 32'h0);

        // R1 unused bits with everything active
        ev_frame_err = 1; ev_cmp_hit = 1; ev_underrun = 1; ev_cs_rise = 1;
        ev_mode_fault = 1; ev_rx_ptr_err = 1; ev_tx_ptr_err = 1; rx_load = 1;
        rx_level = 0; tx_level = 8;
        tick(); quiet();
        chk("R1 unused zero", status & 32'h00FE_E0F0, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule